// File: doc/BRIEF.md
# SCSI Controller Command Decoder

This block sits behind the command register of a SCSI protocol controller. Each byte written to that register is decoded here. The top bit of the byte asks for a DMA transfer. It is split off and reported on its own, and the remaining seven bits select the command. The block then updates three registers:

- the interrupt-cause register;
- the sequence-step register;
- the bus-phase and status register.

It also drives the controller's interrupt line and issues a one-cycle action strobe. Neighbouring logic uses that strobe to carry out the command.

The block does not signal on the SCSI bus and does not model targets. A selection command only pulses a start strobe together with a mode code. Codes the block does not know produce an illegal-command strobe and leave every register untouched. The bus-reset command can be told not to raise an interrupt through one bit of the first configuration register.

Top module: `scsi_cmd_decoder`

## Requirements
- R1: After reset, `intr_reg`, `seq_step`, `status` and `irq` are zero and every strobe, `irq_raise` and `dma_flag` are low.
- R2: Bit 7 of `cmd_byte` is removed before decoding, so a code with bit 7 set acts exactly like the same code with bit 7 clear. `dma_flag` shows bit 7 during the cycle after the write.
- R3: Code 0x00 changes no register and pulses no strobe.
- R4: Code 0x01 pulses `flush_stb`, sets `intr_reg` to 0x08 (function complete), clears `seq_step` and raises `irq`.
- R5: Code 0x02 pulses `chip_rst_stb` and clears `intr_reg`, `seq_step`, `status` and `irq`.
- R6: Code 0x03 pulses `bus_rst_stb` and sets `intr_reg` to 0x80. It raises `irq` only when `cfg1` bit 6 is clear; when that bit is set, `irq` keeps its value.
- R7: Code 0x11 pulses `iccs_stb`, sets `intr_reg` to 0x08, sets `status[2:0]` to 3'b111 (message-in phase) while keeping the other status bits, and raises `irq`.
- R8: Code 0x12 pulses `msg_acc_stb`, sets `intr_reg` to 0x20 (disconnect), clears `seq_step` and raises `irq`.
- R9: Code 0x1a pulses `set_atn_stb`, and codes 0x41 and 0x42 pulse `sel_start` with `sel_mode` 0 and 1; none of these change a register. Code 0x44 pulses `en_sel_stb` and clears `intr_reg` only.
- R10: Code 0x43 pulses `sel_start` with `sel_mode` 2. It sets `status` to 0x12 (terminal count bit 4 plus command phase 3'b010), `intr_reg` to 0x18 (bus service plus function complete) and `seq_step` to 4 (command done), and raises `irq`.
- R11: Any other 7-bit code pulses `illegal_stb` and changes no register and no `irq`.
- R12: All outputs update on the clock edge that samples `cmd_we`. Strobes last one cycle. `irq_raise` pulses only when `irq` goes from 0 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Write strobe for the command register |
| cmd_byte | input | 8 | Command byte written |
| cfg1 | input | 8 | Configuration register 1; bit 6 mutes the bus-reset interrupt |
| intr_reg | output | 8 | Interrupt-cause register |
| seq_step | output | 3 | Sequence-step register |
| status | output | 8 | Bus phase and status register |
| irq | output | 1 | Interrupt line level |
| irq_raise | output | 1 | One-cycle pulse when irq rises |
| dma_flag | output | 1 | DMA bit of the last written command |
| flush_stb | output | 1 | FIFO flush action |
| chip_rst_stb | output | 1 | Soft chip reset action |
| bus_rst_stb | output | 1 | SCSI bus reset action |
| iccs_stb | output | 1 | Initiator command-complete sequence action |
| msg_acc_stb | output | 1 | Message accepted action |
| set_atn_stb | output | 1 | Assert ATN action |
| sel_start | output | 1 | Start a selection |
| sel_mode | output | 2 | Selection mode: 0 no ATN, 1 ATN, 2 ATN and stop |
| en_sel_stb | output | 1 | Enable reselection action |
| illegal_stb | output | 1 | Unknown command code |

## Verification
Two conditions are the hardest to reach from the ports: a bus reset that is muted while `irq` is already high, and a status merge on top of a non-zero status. To reach them, the bench writes every one of the 256 byte values after each of two prepared states. One state follows a chip reset and leaves everything at zero. The other follows a select-with-stop, which leaves `irq`, `status` and `seq_step` non-zero. Each of these combinations is run with the configuration bit both clear and set. A reference model in the bench, built from the requirements, predicts every register and strobe after each write. The bench also checks that all strobes fall again on the idle cycle that follows.

// File: rtl/scsi_cmd_decoder.sv
module scsi_cmd_decoder #(
  parameter int         MUTE_BIT = 6,
  parameter logic [2:0] SEQ_DONE = 3'd4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic [7:0] cmd_byte,
  input  logic [7:0] cfg1,
  output logic [7:0] intr_reg,
  output logic [2:0] seq_step,
  output logic [7:0] status,
  output logic       irq,
  output logic       irq_raise,
  output logic       dma_flag,
  output logic       flush_stb,
  output logic       chip_rst_stb,
  output logic       bus_rst_stb,
  output logic       iccs_stb,
  output logic       msg_acc_stb,
  output logic       set_atn_stb,
  output logic       sel_start,
  output logic [1:0] sel_mode,
  output logic       en_sel_stb,
  output logic       illegal_stb
);
  localparam logic [7:0] I_FC = 8'h08;
  localparam logic [7:0] I_BS = 8'h10;
  localparam logic [7:0] I_DC = 8'h20;
  localparam logic [7:0] I_RST = 8'h80;
  localparam logic [7:0] S_TC = 8'h10;
  localparam logic [2:0] PH_CMD = 3'b010;
  localparam logic [2:0] PH_MSGIN = 3'b111;
  localparam int NSTB = 9;

  logic [6:0]      code;
  logic [7:0]      n_intr, n_status;
  logic [2:0]      n_seq;
  logic            want_raise, want_drop;
  logic [NSTB-1:0] n_stb, stb_q;
  logic [1:0]      n_mode;

  assign code = cmd_byte[6:0];

  always_comb begin
    n_intr     = intr_reg;
    n_seq      = seq_step;
    n_status   = status;
    want_raise = 1'b0;
    want_drop  = 1'b0;
    n_stb      = '0;
    n_mode     = sel_mode;
    case (code)
      7'h00: ;
      7'h01: begin n_stb[0] = 1'b1; n_intr = I_FC; n_seq = 3'd0; want_raise = 1'b1; end
      7'h02: begin
        n_stb[1] = 1'b1; n_intr = 8'h00; n_seq = 3'd0; n_status = 8'h00; want_drop = 1'b1;
      end
      7'h03: begin n_stb[2] = 1'b1; n_intr = I_RST; want_raise = !cfg1[MUTE_BIT]; end
      7'h11: begin
        n_stb[3] = 1'b1; n_intr = I_FC; n_status = {status[7:3], PH_MSGIN}; want_raise = 1'b1;
      end
      7'h12: begin n_stb[4] = 1'b1; n_intr = I_DC; n_seq = 3'd0; want_raise = 1'b1; end
      7'h1a: n_stb[5] = 1'b1;
      7'h41: begin n_stb[6] = 1'b1; n_mode = 2'd0; end
      7'h42: begin n_stb[6] = 1'b1; n_mode = 2'd1; end
      7'h43: begin
        n_stb[6] = 1'b1; n_mode = 2'd2;
        n_status = S_TC | {5'd0, PH_CMD}; n_intr = I_BS | I_FC; n_seq = SEQ_DONE;
        want_raise = 1'b1;
      end
      7'h44: begin n_stb[7] = 1'b1; n_intr = 8'h00; end
      default: n_stb[8] = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      intr_reg  <= '0;
      seq_step  <= '0;
      status    <= '0;
      irq       <= 1'b0;
      irq_raise <= 1'b0;
      dma_flag  <= 1'b0;
      stb_q     <= '0;
      sel_mode  <= '0;
    end else if (cmd_we) begin
      intr_reg  <= n_intr;
      seq_step  <= n_seq;
      status    <= n_status;
      irq       <= want_drop ? 1'b0 : (irq | want_raise);
      irq_raise <= want_raise && !irq;
      dma_flag  <= cmd_byte[7];
      stb_q     <= n_stb;
      sel_mode  <= n_mode;
    end else begin
      irq_raise <= 1'b0;
      dma_flag  <= 1'b0;
      stb_q     <= '0;
    end
  end

  assign {illegal_stb, en_sel_stb, sel_start, set_atn_stb, msg_acc_stb,
          iccs_stb, bus_rst_stb, chip_rst_stb, flush_stb} = stb_q;

  assert_strobe_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({illegal_stb, en_sel_stb, sel_start, set_atn_stb, msg_acc_stb,
              iccs_stb, bus_rst_stb, chip_rst_stb, flush_stb}));

  assert_strobe_after_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (|stb_q || irq_raise) |-> $past(cmd_we));

  assert_chip_reset_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    chip_rst_stb |-> (!irq && intr_reg == 8'h00 && seq_step == 3'd0 && status == 8'h00));

  assert_raise_edge_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_raise |-> (irq && !$past(irq)));

  assert_bus_reset_muted_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_byte[6:0] == 7'h03 && cfg1[MUTE_BIT]) |=> (!irq_raise && $stable(irq)));

  assert_illegal_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_stb |-> ($stable(intr_reg) && $stable(seq_step) && $stable(status) && $stable(irq)));

  assert_select_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_start && sel_mode == 2'd2) |-> (irq && status[4] && seq_step == SEQ_DONE));
endmodule

// File: tb/test_scsi_cmd_decoder.sv
module test_scsi_cmd_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_we = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic [7:0] cfg1 = 8'h00;
  logic [7:0] intr_reg, status;
  logic [2:0] seq_step;
  logic irq, irq_raise, dma_flag, flush_stb, chip_rst_stb, bus_rst_stb, iccs_stb;
  logic msg_acc_stb, set_atn_stb, sel_start, en_sel_stb, illegal_stb;
  logic [1:0] sel_mode;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_intr = 0, m_status = 0;
  logic [2:0] m_seq = 0;
  logic m_irq = 0;
  logic [1:0] m_mode = 0;

  always #4 clk = ~clk;

  scsi_cmd_decoder i_scsi_cmd_decoder (.*);

  function automatic string tag_of(input logic [7:0] c);
    if (c[7]) return "R2";
    case (c[6:0])
      7'h00: return "R3";
      7'h01: return "R4";
      7'h02: return "R5";
      7'h03: return "R6";
      7'h11: return "R7";
      7'h12: return "R8";
      7'h1a, 7'h41, 7'h42, 7'h44: return "R9";
      7'h43: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] c);
    logic [8:0] e_stb = '0;
    logic e_raise = 1'b0;
    logic want = 1'b0;
    string t = tag_of(c);
    case (c[6:0])
      7'h00: ;
      7'h01: begin e_stb[0] = 1; m_intr = 8'h08; m_seq = 0; want = 1; end
      7'h02: begin e_stb[1] = 1; m_intr = 0; m_seq = 0; m_status = 0; m_irq = 0; end
      7'h03: begin e_stb[2] = 1; m_intr = 8'h80; want = !cfg1[6]; end
      7'h11: begin e_stb[3] = 1; m_intr = 8'h08; m_status = m_status | 8'h07; want = 1; end
      7'h12: begin e_stb[4] = 1; m_intr = 8'h20; m_seq = 0; want = 1; end
      7'h1a: e_stb[5] = 1;
      7'h41: begin e_stb[6] = 1; m_mode = 0; end
      7'h42: begin e_stb[6] = 1; m_mode = 1; end
      7'h43: begin e_stb[6] = 1; m_mode = 2; m_status = 8'h12; m_intr = 8'h18; m_seq = 4; want = 1; end
      7'h44: begin e_stb[7] = 1; m_intr = 0; end
      default: e_stb[8] = 1;
    endcase
    if (want) begin e_raise = !m_irq; m_irq = 1; end
    cmd_byte = c;
    cmd_we = 1'b1;
    @(negedge clk);
    cmd_we = 1'b0;
    check(t, "intr_reg", intr_reg, m_intr);
    check(t, "seq_step", seq_step, m_seq);
    check(t, "status", status, m_status);
    check(t, "irq", irq, m_irq);
    check(t, "irq_raise R12", irq_raise, e_raise);
    check(t, "strobes", {illegal_stb, en_sel_stb, sel_start, set_atn_stb, msg_acc_stb,
                         iccs_stb, bus_rst_stb, chip_rst_stb, flush_stb}, e_stb);
    check("R2", "dma_flag", dma_flag, c[7]);
    if (e_stb[6]) check(t, "sel_mode", sel_mode, m_mode);
    @(negedge clk);
    check("R12", "strobes after idle", {illegal_stb, en_sel_stb, sel_start, set_atn_stb,
          msg_acc_stb, iccs_stb, bus_rst_stb, chip_rst_stb, flush_stb, irq_raise, dma_flag}, 0);
    check("R12", "registers hold when idle", {intr_reg, seq_step, status, irq},
          {m_intr, m_seq, m_status, m_irq});
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "reset regs", {intr_reg, seq_step, status, irq}, 0);
    check("R1", "reset strobes", {illegal_stb, en_sel_stb, sel_start, set_atn_stb, msg_acc_stb,
          iccs_stb, bus_rst_stb, chip_rst_stb, flush_stb, irq_raise, dma_flag}, 0);
    for (int cf = 0; cf < 2; cf++) begin
      cfg1 = cf[0] ? 8'h47 : 8'hb7 & ~8'h40;
      for (int pre = 0; pre < 2; pre++) begin
        for (int c = 0; c < 256; c++) begin
          apply(8'h02);
          if (pre == 1) apply(8'hc3);
          apply(c[7:0]);
        end
      end
    end
    apply(8'h02);
    apply(8'h01);
    apply(8'h12);
    apply(8'h11);
    apply(8'h11);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule